// File: doc/BRIEF.md
# Ultra DMA Data-Out Burst Receiver

This block is the device-side receive engine for one host-to-device Ultra DMA burst. When enabled, with a non-zero word count for the command and room in the sink buffer, it raises its burst request. It waits for the host's acknowledge, and then holds its ready line negated until the host lifts its halt line. After that it asserts ready and captures one 16-bit word on every transition of the host strobe, rising and falling alike. The strobe, data, acknowledge and halt inputs are all brought into the local clock domain through a synchroniser chain, and an edge detector on the synchronised strobe marks each transition.

Each captured word pulses a strobe toward the CRC unit. Only words inside the remaining count also go to the sink buffer as valid data. The engine pauses by negating ready when the sink buffer is nearly full, since up to two words may already be on the cable. It ends the burst itself once the count is used up: it negates ready, waits a programmable number of cycles, then drops its request. If the host halts first, the request drops at once and any later strobe transition is ignored. When the acknowledge is released, the data lines are captured as the host's CRC.

States: `ST_IDLE` (nothing requested), `ST_REQ` (request raised, no acknowledge), `ST_ARMED` (acknowledged, host still halting, ready negated), `ST_XFER` (ready asserted, capturing), `ST_PAUSE` (ready negated for buffer space, still capturing), `ST_DRAIN` (count reached, ready negated, still capturing, request held for the drain time), `ST_TAIL` (request dropped, strobe ignored, waiting for acknowledge release).

Transitions:
- IDLE→REQ on enable, non-zero count and free space above the margin. The count is loaded here.
- REQ→ARMED on acknowledge.
- ARMED→XFER when halt is released.
- XFER→PAUSE when a word has been seen and free space is at or below the margin.
- PAUSE→XFER when space returns.
- XFER or PAUSE→DRAIN when the count reaches zero.
- DRAIN→TAIL after the drain time.
- XFER, PAUSE or DRAIN→TAIL on host halt.
- Any state from ARMED to TAIL→IDLE on acknowledge release, which also captures the CRC.

Top module: `udma_out_rx`

## Requirements
- R1: After reset the request output is low, ready is negated (high), the ready driver is off, and no word, CRC-strobe or host-CRC pulse is present.
- R2: With enable high, a non-zero count and free space above the margin, the request goes high. After the acknowledge (active low) is seen, the ready driver turns on while ready stays negated for as long as the host halt is high.
- R3: After the host releases halt during an acknowledged burst, ready is asserted (driven low). Ready is only ever asserted while the request is high.
- R4: In the transfer state every strobe transition, rising or falling, delivers exactly one word on the word-valid output, in arrival order and with the value present on the data lines at that transition, together with a CRC strobe.
- R5: Once a word has been received, free space at or below the margin (3) negates ready while the request stays high. Up to two words that arrive afterwards are still delivered. Free space above the margin re-asserts ready.
- R6: Before the first word of a burst, low free space does not negate ready.
- R7: When the remaining count reaches zero, ready is negated while the request stays high for exactly RP_CYC more cycles (counted from the first cycle with ready negated). The request then drops.
- R8: Words received after the count reached zero produce CRC strobes but no word-valid pulse.
- R9: When the host raises halt during the transfer, the request drops and ready is negated. Strobe transitions after that produce neither a word nor a CRC strobe.
- R10: Release of the acknowledge captures the data lines as the host CRC and gives a single one-cycle valid pulse. The ready driver is off from that cycle on.
- R11: Strobe transitions while halt is still held after acknowledge, or after the request has dropped, are ignored.
- R12: The remaining-word output falls by one with each word-valid pulse and reaches zero after the count is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_en_i | input | 1 | Allows a new burst request |
| cmd_words_i | input | CNT_W | Words still needed by the command, loaded at request |
| sink_free_i | input | FREE_W | Free slots in the sink buffer |
| bus_ack_n_i | input | 1 | Host acknowledge, active low |
| host_halt_i | input | 1 | Host halt/stop line, active high |
| host_strb_i | input | 1 | Host data strobe, both edges carry data |
| bus_data_i | input | DATA_W | Bus data lines |
| bus_req_o | output | 1 | Burst request to the host |
| dev_rdy_n_o | output | 1 | Device ready, active low |
| dev_rdy_oe_o | output | 1 | Drive enable for the ready line |
| word_vld_o | output | 1 | One-cycle pulse: word for the sink buffer |
| word_data_o | output | DATA_W | Captured word (for sink and CRC unit) |
| crc_stb_o | output | 1 | One-cycle pulse: word for the CRC unit |
| words_left_o | output | CNT_W | Remaining words for the command |
| host_crc_o | output | DATA_W | CRC value received from the host |
| host_crc_vld_o | output | 1 | One-cycle pulse when host CRC is captured |

## Verification
The bench builds the block with SYNC_STAGES=2, PAUSE_MARGIN=3, an 8-bit count and RP_CYC=12. The long drain time leaves room for two surplus host words to cross the synchroniser and land inside the drain window, so the rule that only the CRC sees them can be observed. The two-stage chain and the 4-cycle host word period let the test place in-flight words after a pause request and check that exactly those words are kept. The margin of 3 is reached by setting the free-slot input directly, both before the first word (where it must be ignored) and mid-burst.

// File: rtl/udr_pkg.sv
package udr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ARMED,
        ST_XFER,
        ST_PAUSE,
        ST_DRAIN,
        ST_TAIL
    } udr_state_e;

endpackage

// File: rtl/udr_sync.sv
module udr_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/udr_edge.sv
module udr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_s_i,
    output logic edge_o
);

    logic strb_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strb_prev <= 1'b1;
        else        strb_prev <= strb_s_i;
    end

    assign edge_o = strb_s_i ^ strb_prev;

endmodule

// File: rtl/udr_wordpath.sv
module udr_wordpath #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CNT_W-1:0]  load_cnt_i,
    input  logic              cap_en_i,
    input  logic              edge_i,
    input  logic              end_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              word_vld_o,
    output logic [DATA_W-1:0] word_o,
    output logic              crc_stb_o,
    output logic [CNT_W-1:0]  left_o,
    output logic              left_zero_o,
    output logic              seen_o,
    output logic [DATA_W-1:0] host_crc_o,
    output logic              host_crc_vld_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_vld_o     <= 1'b0;
            word_o         <= '0;
            crc_stb_o      <= 1'b0;
            left_o         <= '0;
            seen_o         <= 1'b0;
            host_crc_o     <= '0;
            host_crc_vld_o <= 1'b0;
        end else begin
            word_vld_o     <= 1'b0;
            crc_stb_o      <= 1'b0;
            host_crc_vld_o <= 1'b0;
            if (load_i) begin
                left_o <= load_cnt_i;
                seen_o <= 1'b0;
            end else if (cap_en_i && edge_i) begin
                crc_stb_o <= 1'b1;
                word_o    <= data_i;
                seen_o    <= 1'b1;
                if (left_o != '0) begin
                    word_vld_o <= 1'b1;
                    left_o     <= left_o - CNT_W'(1);
                end
            end
            if (end_i) begin
                host_crc_o     <= data_i;
                host_crc_vld_o <= 1'b1;
            end
        end
    end

    assign left_zero_o = (left_o == '0);

endmodule

// File: rtl/udr_fsm.sv
module udr_fsm
    import udr_pkg::*;
#(
    parameter int RP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic cmd_nz_i,
    input  logic free_ok_i,
    input  logic ack_i,
    input  logic halt_i,
    input  logic left_zero_i,
    input  logic seen_i,
    output logic load_o,
    output logic cap_en_o,
    output logic end_o,
    output logic req_o,
    output logic rdy_n_o,
    output logic rdy_oe_o
);

    localparam int RP_W = (RP_CYC < 2) ? 1 : $clog2(RP_CYC);

    udr_state_e state, nxt;
    logic [RP_W-1:0] rp_cnt;
    logic            in_burst;

    assign in_burst = (state == ST_ARMED) || (state == ST_XFER) || (state == ST_PAUSE) ||
                      (state == ST_DRAIN) || (state == ST_TAIL);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (en_i && cmd_nz_i && free_ok_i) nxt = ST_REQ;
            ST_REQ:   if (ack_i) nxt = ST_ARMED;
            ST_ARMED: begin
                if (!ack_i)       nxt = ST_IDLE;
                else if (!halt_i) nxt = ST_XFER;
            end
            ST_XFER: begin
                if (!ack_i)                      nxt = ST_IDLE;
                else if (halt_i)                 nxt = ST_TAIL;
                else if (seen_i && left_zero_i)  nxt = ST_DRAIN;
                else if (seen_i && !free_ok_i)   nxt = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (!ack_i)           nxt = ST_IDLE;
                else if (halt_i)      nxt = ST_TAIL;
                else if (left_zero_i) nxt = ST_DRAIN;
                else if (free_ok_i)   nxt = ST_XFER;
            end
            ST_DRAIN: begin
                if (!ack_i)                             nxt = ST_IDLE;
                else if (halt_i)                        nxt = ST_TAIL;
                else if (rp_cnt == RP_W'(RP_CYC - 1))   nxt = ST_TAIL;
            end
            ST_TAIL:  if (!ack_i) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            rp_cnt <= '0;
        end else begin
            state  <= nxt;
            rp_cnt <= (state == ST_DRAIN) ? rp_cnt + RP_W'(1) : '0;
        end
    end

    always_comb begin
        load_o   = (state == ST_IDLE) && (nxt == ST_REQ);
        end_o    = in_burst && !ack_i;
        cap_en_o = 1'b0;
        req_o    = 1'b0;
        rdy_n_o  = 1'b1;
        rdy_oe_o = in_burst;
        unique case (state)
            ST_IDLE:  ;
            ST_REQ:   req_o = 1'b1;
            ST_ARMED: req_o = 1'b1;
            ST_XFER: begin
                req_o    = 1'b1;
                rdy_n_o  = 1'b0;
                cap_en_o = 1'b1;
            end
            ST_PAUSE: begin
                req_o    = 1'b1;
                cap_en_o = 1'b1;
            end
            ST_DRAIN: begin
                req_o    = 1'b1;
                cap_en_o = 1'b1;
            end
            ST_TAIL:  ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/udma_out_rx.sv
module udma_out_rx #(
    parameter int DATA_W       = 16,
    parameter int CNT_W        = 16,
    parameter int FREE_W       = 6,
    parameter int PAUSE_MARGIN = 3,
    parameter int RP_CYC       = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_en_i,
    input  logic [CNT_W-1:0]  cmd_words_i,
    input  logic [FREE_W-1:0] sink_free_i,
    input  logic              bus_ack_n_i,
    input  logic              host_halt_i,
    input  logic              host_strb_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic              bus_req_o,
    output logic              dev_rdy_n_o,
    output logic              dev_rdy_oe_o,
    output logic              word_vld_o,
    output logic [DATA_W-1:0] word_data_o,
    output logic              crc_stb_o,
    output logic [CNT_W-1:0]  words_left_o,
    output logic [DATA_W-1:0] host_crc_o,
    output logic              host_crc_vld_o
);

    localparam int            SW      = DATA_W + 3;
    localparam logic [SW-1:0] SYNC_RV = {1'b1, 1'b0, 1'b1, {DATA_W{1'b0}}};

    logic [SW-1:0]     sync_q;
    logic              ack_n_s, halt_s, strb_s;
    logic [DATA_W-1:0] data_s;
    logic              strb_edge;
    logic              load, cap_en, end_ev, left_zero, seen;
    logic              free_ok;

    udr_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RV)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bus_ack_n_i, host_halt_i, host_strb_i, bus_data_i}),
        .q_o   (sync_q)
    );

    assign {ack_n_s, halt_s, strb_s, data_s} = sync_q;
    assign free_ok = (sink_free_i > FREE_W'(PAUSE_MARGIN));

    udr_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb_s_i (strb_s),
        .edge_o   (strb_edge)
    );

    udr_fsm #(.RP_CYC(RP_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (burst_en_i),
        .cmd_nz_i    (cmd_words_i != '0),
        .free_ok_i   (free_ok),
        .ack_i       (!ack_n_s),
        .halt_i      (halt_s),
        .left_zero_i (left_zero),
        .seen_i      (seen),
        .load_o      (load),
        .cap_en_o    (cap_en),
        .end_o       (end_ev),
        .req_o       (bus_req_o),
        .rdy_n_o     (dev_rdy_n_o),
        .rdy_oe_o    (dev_rdy_oe_o)
    );

    udr_wordpath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_path (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_i         (load),
        .load_cnt_i     (cmd_words_i),
        .cap_en_i       (cap_en),
        .edge_i         (strb_edge),
        .end_i          (end_ev),
        .data_i         (data_s),
        .word_vld_o     (word_vld_o),
        .word_o         (word_data_o),
        .crc_stb_o      (crc_stb_o),
        .left_o         (words_left_o),
        .left_zero_o    (left_zero),
        .seen_o         (seen),
        .host_crc_o     (host_crc_o),
        .host_crc_vld_o (host_crc_vld_o)
    );

endmodule

// File: rtl/udr_checker.sv
module udr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req_o,
    input logic             dev_rdy_n_o,
    input logic             dev_rdy_oe_o,
    input logic             word_vld_o,
    input logic             crc_stb_o,
    input logic [CNT_W-1:0] words_left_o,
    input logic             host_crc_vld_o
);

    a_r3_rdy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rdy_n_o |-> bus_req_o);

    a_r2_rdy_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rdy_n_o |-> dev_rdy_oe_o);

    a_r4_word_has_crc: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> crc_stb_o);

    a_r11_word_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> $past(bus_req_o));

    a_r12_left_steps: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> (words_left_o == $past(words_left_o) - CNT_W'(1)));

    a_r10_crc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_crc_vld_o |=> !host_crc_vld_o);

    a_r10_oe_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        host_crc_vld_o |-> !dev_rdy_oe_o);

endmodule

bind udma_out_rx udr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_req_o      (bus_req_o),
    .dev_rdy_n_o    (dev_rdy_n_o),
    .dev_rdy_oe_o   (dev_rdy_oe_o),
    .word_vld_o     (word_vld_o),
    .crc_stb_o      (crc_stb_o),
    .words_left_o   (words_left_o),
    .host_crc_vld_o (host_crc_vld_o)
);

// File: tb/sim_udma_out_rx.sv
module sim_udma_out_rx;

    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;
    localparam int FREE_W = 6;
    localparam int MARGIN = 3;
    localparam int RP     = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              burst_en = 1'b0;
    logic [CNT_W-1:0]  cmd_words = '0;
    logic [FREE_W-1:0] sink_free = 6'd20;
    logic              ack_n = 1'b1;
    logic              halt = 1'b1;
    logic              strb = 1'b1;
    logic [DATA_W-1:0] bdata = '0;
    logic              req, rdy_n, rdy_oe, wvld, cstb, hvld;
    logic [DATA_W-1:0] wdata, hcrc;
    logic [CNT_W-1:0]  left;

    always #10 clk = ~clk;

    udma_out_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W), .FREE_W(FREE_W),
                  .PAUSE_MARGIN(MARGIN), .RP_CYC(RP), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .burst_en_i(burst_en), .cmd_words_i(cmd_words),
        .sink_free_i(sink_free), .bus_ack_n_i(ack_n), .host_halt_i(halt),
        .host_strb_i(strb), .bus_data_i(bdata), .bus_req_o(req),
        .dev_rdy_n_o(rdy_n), .dev_rdy_oe_o(rdy_oe), .word_vld_o(wvld),
        .word_data_o(wdata), .crc_stb_o(cstb), .words_left_o(left),
        .host_crc_o(hcrc), .host_crc_vld_o(hvld)
    );

    int n_chk = 0, n_bad = 0;
    int rx_n = 0, crc_n = 0, hv_n = 0;
    logic [DATA_W-1:0] rx_buf [64];
    logic [DATA_W-1:0] last_hcrc = '0;
    bit done = 0;

    always @(negedge clk) begin
        if (wvld) begin
            if (rx_n < 64) rx_buf[rx_n] <= wdata;
            rx_n <= rx_n + 1;
        end
        if (cstb) crc_n <= crc_n + 1;
        if (hvld) begin
            hv_n      <= hv_n + 1;
            last_hcrc <= hcrc;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic [DATA_W-1:0] d);
        @(negedge clk) bdata = d;
        @(negedge clk) strb = ~strb;
        wait_n(2);
    endtask

    task automatic open_burst(input int words);
        @(negedge clk);
        cmd_words = CNT_W'(words);
        burst_en  = 1'b1;
        halt      = 1'b1;
        strb      = 1'b1;
        wait_n(3);
        chk(req == 1'b1, "R2 request raised", int'(req), 1);
        burst_en = 1'b0;
        ack_n    = 1'b0;
        wait_n(5);
    endtask

    task automatic close_burst(input logic [DATA_W-1:0] crc, input string tag);
        int hv0;
        hv0 = hv_n;
        @(negedge clk);
        halt = 1'b1;
        if (strb == 1'b0) strb = 1'b1;
        wait_n(3);
        bdata = crc;
        wait_n(3);
        ack_n = 1'b1;
        wait_n(6);
        chk(last_hcrc == crc, {tag, " host crc value"}, int'(last_hcrc), int'(crc));
        chk(hv_n == hv0 + 1, {tag, " host crc single pulse"}, hv_n - hv0, 1);
        chk(rdy_oe == 1'b0, {tag, " ready driver off"}, int'(rdy_oe), 0);
    endtask

    task automatic t_reset;
        chk(req == 1'b0,    "R1 reset request",  int'(req), 0);
        chk(rdy_n == 1'b1,  "R1 reset ready",    int'(rdy_n), 1);
        chk(rdy_oe == 1'b0, "R1 reset driver",   int'(rdy_oe), 0);
        chk(!wvld && !cstb && !hvld, "R1 reset pulses", int'({wvld, cstb, hvld}), 0);
    endtask

    task automatic t_basic;
        int rx0, c0, seen_rdy;
        rx0 = rx_n;
        open_burst(6);
        chk(rdy_oe == 1'b1, "R2 driver on after ack", int'(rdy_oe), 1);
        chk(rdy_n == 1'b1,  "R2 ready held while halted", int'(rdy_n), 1);
        c0 = crc_n;
        @(negedge clk) strb = 1'b0;
        wait_n(3);
        strb = 1'b1;
        wait_n(4);
        chk(crc_n == c0, "R11 strobe ignored while halted", crc_n - c0, 0);
        halt = 1'b0;
        wait_n(5);
        chk(rdy_n == 1'b0, "R3 ready asserted after halt release", int'(rdy_n), 0);
        sink_free = 6'd2;
        wait_n(4);
        chk(rdy_n == 1'b0, "R6 no pause before first word", int'(rdy_n), 0);
        sink_free = 6'd20;
        for (int i = 0; i < 6; i++) send_word(16'h1100 + DATA_W'(i * 7));
        seen_rdy = 0;
        for (int k = 0; k < 20 && !seen_rdy; k++) begin
            if (rdy_n) seen_rdy = 1;
            else @(negedge clk);
        end
        chk(seen_rdy == 1, "R7 ready negated at count end", seen_rdy, 1);
        for (int k = 0; k < RP; k++) begin
            chk(req == 1'b1, "R7 request held during drain", int'(req), 1);
            @(negedge clk);
        end
        chk(req == 1'b0, "R7 request dropped after drain", int'(req), 0);
        chk(rx_n - rx0 == 6, "R4 word count", rx_n - rx0, 6);
        for (int i = 0; i < 6; i++)
            chk(rx_buf[rx0 + i] == 16'h1100 + DATA_W'(i * 7), "R4 word value/order",
                int'(rx_buf[rx0 + i]), int'(16'h1100 + DATA_W'(i * 7)));
        chk(left == '0, "R12 remaining count at zero", int'(left), 0);
        c0 = crc_n;
        @(negedge clk) strb = 1'b0;
        wait_n(3);
        strb = 1'b1;
        wait_n(4);
        chk(crc_n == c0 && rx_n - rx0 == 6, "R11 strobe ignored after request drop", crc_n - c0, 0);
        close_burst(16'hBEEF, "R10");
    endtask

    task automatic t_pause;
        int rx0, c0, seen_drop;
        rx0 = rx_n;
        c0  = crc_n;
        open_burst(10);
        halt = 1'b0;
        wait_n(4);
        send_word(16'hA000);
        send_word(16'hA001);
        sink_free = 6'd3;
        wait_n(4);
        chk(rdy_n == 1'b1, "R5 ready negated at margin", int'(rdy_n), 1);
        chk(req == 1'b1,   "R5 request kept in pause", int'(req), 1);
        send_word(16'hA002);
        send_word(16'hA003);
        wait_n(4);
        chk(rx_n - rx0 == 4, "R5 in-flight words kept", rx_n - rx0, 4);
        chk(left == CNT_W'(6), "R12 remaining after four words", int'(left), 6);
        sink_free = 6'd20;
        wait_n(4);
        chk(rdy_n == 1'b0, "R5 ready resumed", int'(rdy_n), 0);
        for (int i = 4; i < 10; i++) send_word(16'hA000 + DATA_W'(i));
        send_word(16'h5E01);
        send_word(16'h5E02);
        wait_n(4);
        chk(rx_n - rx0 == 10, "R8 surplus words not delivered", rx_n - rx0, 10);
        chk(crc_n - c0 == 12, "R8 surplus words strobed to crc", crc_n - c0, 12);
        for (int i = 0; i < 10; i++)
            chk(rx_buf[rx0 + i] == 16'hA000 + DATA_W'(i), "R4 paused burst order",
                int'(rx_buf[rx0 + i]), int'(16'hA000 + DATA_W'(i)));
        seen_drop = 0;
        for (int k = 0; k < 40 && !seen_drop; k++) begin
            if (!req) seen_drop = 1;
            else @(negedge clk);
        end
        chk(seen_drop == 1, "R7 request dropped after surplus", seen_drop, 1);
        close_burst(16'h0F0F, "R10");
    endtask

    task automatic t_halt;
        int rx0, c0;
        rx0 = rx_n;
        open_burst(10);
        halt = 1'b0;
        wait_n(4);
        send_word(16'h7001);
        send_word(16'h7002);
        send_word(16'h7003);
        wait_n(2);
        halt = 1'b1;
        wait_n(5);
        chk(req == 1'b0,   "R9 request dropped on halt", int'(req), 0);
        chk(rdy_n == 1'b1, "R9 ready negated on halt", int'(rdy_n), 1);
        c0 = crc_n;
        @(negedge clk) strb = ~strb;
        wait_n(5);
        chk(crc_n == c0 && rx_n - rx0 == 3, "R9 strobe after halt ignored", crc_n - c0, 0);
        close_burst(16'h1234, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        t_reset;
        rst_n = 1'b1;
        wait_n(3);
        t_reset;
        t_basic;
        t_pause;
        t_halt;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule